// File: doc/BRIEF.md
# Tri-State Control Serializer

This block turns a small word of parallel output-enable bits, loaded on a slow divided clock, into one serial tri-state control line on a fast clock. It sits beside a data serializer that shares the same clock pair, so that a bidirectional pad can switch between driving and floating at single-bit granularity. A second copy of the serial control goes back to the internal logic.

Bit 0 of each word goes out first. A word captured on one rising edge of the divided clock goes out during the divided period that follows. In double-rate mode two bits leave per fast cycle: the even bit during the high phase of the fast clock and the odd bit during the low phase. In single-rate mode one bit leaves per fast cycle. In buffer mode bit 0 of the input passes straight to the output and the shift path is not used. A clock enable freezes the output. Separate parameters set the value driven during reset and the value driven during the first divided period after reset.

The fast and divided clocks must be phase aligned, with a rising edge of the divided clock on a rising edge of the fast clock. Reset must end so that the first fast edge with reset low is also a divided edge.

Top module: `tctl_serializer`

## Requirements
- R1: While `rst` (active high, synchronous) has been seen high on the previous fast edge, `oe_ser` equals `RST_VAL` in both clock phases (single-rate and double-rate modes).
- R2: During the first divided period after reset is released, `oe_ser` equals `INIT_VAL` in every bit slot.
- R3: A word sampled on a rising edge of `clk_par` is sent during the next divided period, lowest index first.
- R4: In double-rate mode (`TW`=4 at twice the divided rate), bit 2k of the word is driven while `clk_ser` is high and bit 2k+1 while it is low, in fast cycle k after the divided edge.
- R5: In single-rate mode (`TW`=4 at four times the divided rate), bit k is driven for the whole of fast cycle k after the divided edge.
- R6: When `oe_ce` is low at a fast edge, `oe_ser` keeps the last value it showed in both phases. The bits due in that cycle are dropped. Bit slots keep advancing, so after `oe_ce` rises the output carries the bit due in the current slot.
- R7: In buffer mode `oe_ser` follows `oe_par[0]` without delay, whatever the state of `rst` and `oe_ce`.
- R8: `oe_fb` always equals `oe_ser`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast serial clock |
| clk_par | input | 1 | Divided parallel clock, phase aligned to `clk_ser` |
| rst | input | 1 | Synchronous reset, active high |
| oe_ce | input | 1 | Update enable for the serial control, sampled on `clk_ser` |
| oe_par | input | TW | Parallel tri-state word, bit 0 sent first |
| oe_ser | output | 1 | Serial tri-state control toward the pad |
| oe_fb | output | 1 | Copy of the serial control for internal logic |

## Verification
A table of words is streamed through the double-rate instance with no gaps. Its patterns include alternating bits (0x5, 0xA), half words (0x3, 0xC), all ones and all zeros, and asymmetric words (0x9, 0x6). These separate the high-phase slot from the low-phase slot, separate a swapped bit order from the correct one, and show whether the word-load timing slips by a period. A second table runs through the single-rate instance and covers the one-bit-per-cycle ordering. Directed cases cover the reset value, the initial value after release, a clock-enable hold in which the held value differs from the words that arrive meanwhile, resumption mid-word after the enable returns, and buffer mode under reset and with the enable low.

// File: rtl/tctl_pkg.sv
package tctl_pkg;

    typedef enum logic [1:0] {
        RATE_SDR = 2'd0,
        RATE_DDR = 2'd1,
        RATE_BUF = 2'd2
    } rate_e;

    // Bits leaving per fast clock cycle.
    function automatic int bits_per_cycle(int tw, rate_e r);
        return (r == RATE_DDR && tw > 1) ? 2 : 1;
    endfunction

    // Fast cycles per divided period.
    function automatic int phases(int tw, rate_e r);
        int p;
        p = tw / bits_per_cycle(tw, r);
        return (p < 1) ? 1 : p;
    endfunction

    function automatic int cnt_width(int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tctl_word_capture.sv
module tctl_word_capture #(
    parameter int   TW       = 4,
    parameter logic INIT_VAL = 1'b0
) (
    input  logic          clk_par,
    input  logic          rst,
    input  logic [TW-1:0] word_in,
    output logic [TW-1:0] word_q
);

    logic [TW-1:0] word_d;

    always_comb begin
        word_d = word_in;
    end

    // After reset the first word loaded by the fast side is all INIT_VAL.
    always_ff @(posedge clk_par) begin
        if (rst) begin
            word_q <= {TW{INIT_VAL}};
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/tctl_shift_core.sv
module tctl_shift_core #(
    parameter int              TW       = 4,
    parameter tctl_pkg::rate_e RATE     = tctl_pkg::RATE_DDR,
    parameter logic            INIT_VAL = 1'b0,
    parameter logic            RST_VAL  = 1'b0
) (
    input  logic                                                         clk_ser,
    input  logic                                                         rst,
    input  logic                                                         ce,
    input  logic [TW-1:0]                                                par_word,
    output logic [tctl_pkg::cnt_width(tctl_pkg::phases(TW, RATE))-1:0]   cnt_o,
    output logic                                                         hi_o,
    output logic                                                         lo_o
);

    localparam int BPC = tctl_pkg::bits_per_cycle(TW, RATE);
    localparam int NPH = tctl_pkg::phases(TW, RATE);
    localparam int CW  = tctl_pkg::cnt_width(NPH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] sh;
        logic          hi;
        logic          lo;
    } core_t;

    core_t state_q;
    core_t state_d;

    logic [TW-1:0] word;
    logic          nxt_hi;
    logic          nxt_lo;

    always_comb begin
        state_d = state_q;
        // Slot 0 of a period takes a fresh word, later slots use the remainder.
        word    = (state_q.cnt == '0) ? par_word : state_q.sh;
        nxt_hi  = word[0];
        nxt_lo  = word[BPC-1];
        state_d.sh = word >> BPC;
        if (ce) begin
            state_d.hi = nxt_hi;
            state_d.lo = nxt_lo;
        end else begin
            // Freeze on the value most recently shown.
            state_d.hi = state_q.lo;
            state_d.lo = state_q.lo;
        end
        if (state_q.cnt == CW'(NPH - 1)) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_ser) begin
        if (rst) begin
            state_q.cnt <= '0;
            state_q.sh  <= {TW{INIT_VAL}};
            state_q.hi  <= RST_VAL;
            state_q.lo  <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;
    assign hi_o  = state_q.hi;
    assign lo_o  = state_q.lo;

endmodule

// File: rtl/tctl_out_select.sv
module tctl_out_select #(
    parameter int              TW   = 4,
    parameter tctl_pkg::rate_e RATE = tctl_pkg::RATE_DDR
) (
    input  logic clk_ser,
    input  logic hi,
    input  logic lo,
    input  logic bypass_bit,
    output logic ser_out
);

    localparam int  BPC     = tctl_pkg::bits_per_cycle(TW, RATE);
    localparam bit  IS_BUF  = (RATE == tctl_pkg::RATE_BUF);
    localparam bit  IS_DUAL = (BPC == 2);

    logic shifted;

    always_comb begin
        // Dual-rate: high phase shows the even slot, low phase the odd slot.
        shifted = (IS_DUAL && !clk_ser) ? lo : hi;
        ser_out = IS_BUF ? bypass_bit : shifted;
    end

endmodule

// File: rtl/tctl_serializer.sv
module tctl_serializer #(
    parameter int              TW       = 4,
    parameter tctl_pkg::rate_e RATE     = tctl_pkg::RATE_DDR,
    parameter logic            INIT_VAL = 1'b0,
    parameter logic            RST_VAL  = 1'b0
) (
    input  logic          clk_ser,
    input  logic          clk_par,
    input  logic          rst,
    input  logic          oe_ce,
    input  logic [TW-1:0] oe_par,
    output logic          oe_ser,
    output logic          oe_fb
);

    localparam int NPH = tctl_pkg::phases(TW, RATE);
    localparam int CW  = tctl_pkg::cnt_width(NPH);

    logic [TW-1:0] par_word;
    logic [CW-1:0] ph_cnt;
    logic          bit_hi;
    logic          bit_lo;
    logic          ser_w;

    tctl_word_capture #(
        .TW       (TW),
        .INIT_VAL (INIT_VAL)
    ) u_capture (
        .clk_par (clk_par),
        .rst     (rst),
        .word_in (oe_par),
        .word_q  (par_word)
    );

    tctl_shift_core #(
        .TW       (TW),
        .RATE     (RATE),
        .INIT_VAL (INIT_VAL),
        .RST_VAL  (RST_VAL)
    ) u_core (
        .clk_ser  (clk_ser),
        .rst      (rst),
        .ce       (oe_ce),
        .par_word (par_word),
        .cnt_o    (ph_cnt),
        .hi_o     (bit_hi),
        .lo_o     (bit_lo)
    );

    tctl_out_select #(
        .TW   (TW),
        .RATE (RATE)
    ) u_select (
        .clk_ser    (clk_ser),
        .hi         (bit_hi),
        .lo         (bit_lo),
        .bypass_bit (oe_par[0]),
        .ser_out    (ser_w)
    );

    assign oe_ser = ser_w;
    assign oe_fb  = ser_w;

endmodule

// File: rtl/tctl_serializer_chk.sv
module tctl_serializer_chk #(
    parameter int              TW       = 4,
    parameter tctl_pkg::rate_e RATE     = tctl_pkg::RATE_DDR,
    parameter logic            INIT_VAL = 1'b0,
    parameter logic            RST_VAL  = 1'b0
) (
    input logic                                                       clk_ser,
    input logic                                                       rst,
    input logic                                                       oe_ce,
    input logic [TW-1:0]                                              par_word,
    input logic [tctl_pkg::cnt_width(tctl_pkg::phases(TW, RATE))-1:0] cnt,
    input logic                                                       hi,
    input logic                                                       lo
);

    localparam int BPC = tctl_pkg::bits_per_cycle(TW, RATE);
    localparam int NPH = tctl_pkg::phases(TW, RATE);
    localparam int CW  = tctl_pkg::cnt_width(NPH);

    generate
        if (RATE != tctl_pkg::RATE_BUF) begin : g_shift_checks
            // R1: a reset edge leaves the reset value in both slots.
            p_reset_value_r1: assert property (@(posedge clk_ser)
                $past(rst) |-> (hi == RST_VAL && lo == RST_VAL));

            // R6: a disabled edge holds the previously shown value.
            p_ce_hold_r6: assert property (@(posedge clk_ser) disable iff (rst)
                $past(!oe_ce && !rst) |-> (hi == $past(lo) && lo == $past(lo)));

            // R3: the first slot of a period carries bit 0 of the captured word.
            p_first_bit_r3: assert property (@(posedge clk_ser) disable iff (rst)
                $past(oe_ce && !rst && cnt == '0) |-> (hi == $past(par_word[0])));

            // R4: the second half of the first slot carries the next bit.
            p_second_bit_r4: assert property (@(posedge clk_ser) disable iff (rst)
                $past(oe_ce && !rst && cnt == '0) |-> (lo == $past(par_word[BPC-1])));

            // R3: slot counter wraps at the end of each divided period.
            p_slot_wrap_r3: assert property (@(posedge clk_ser) disable iff (rst)
                $past(!rst && cnt == CW'(NPH - 1)) |-> (cnt == '0));
        end
    endgenerate

endmodule

bind tctl_serializer tctl_serializer_chk #(
    .TW       (TW),
    .RATE     (RATE),
    .INIT_VAL (INIT_VAL),
    .RST_VAL  (RST_VAL)
) u_chk (
    .clk_ser  (clk_ser),
    .rst      (rst),
    .oe_ce    (oe_ce),
    .par_word (par_word),
    .cnt      (ph_cnt),
    .hi       (bit_hi),
    .lo       (bit_lo)
);

// File: tb/tb_tctl_serializer.sv
module tb_tctl_serializer;
    import tctl_pkg::*;

    logic        clk_ser  = 1'b0;
    logic        clk_div  = 1'b0;
    logic        clk_div4 = 1'b0;
    int unsigned ph = 0;

    // 50 MHz fast clock; divided clocks rise together with it.
    always #10 begin
        ph++;
        clk_ser  = ~ph[0];
        clk_div  = ph[1];
        clk_div4 = ph[2] ^ ph[1];
    end

    logic       rst;
    logic       ce;
    logic [3:0] par;
    logic       t1;
    logic       ser_d, fb_d, ser_s, fb_s, ser_b, fb_b;

    tctl_serializer #(.TW(4), .RATE(RATE_DDR), .INIT_VAL(1'b0), .RST_VAL(1'b1)) dut (
        .clk_ser(clk_ser), .clk_par(clk_div), .rst(rst), .oe_ce(ce),
        .oe_par(par), .oe_ser(ser_d), .oe_fb(fb_d));

    tctl_serializer #(.TW(4), .RATE(RATE_SDR), .INIT_VAL(1'b1), .RST_VAL(1'b0)) dut_sdr (
        .clk_ser(clk_ser), .clk_par(clk_div4), .rst(rst), .oe_ce(ce),
        .oe_par(par), .oe_ser(ser_s), .oe_fb(fb_s));

    tctl_serializer #(.TW(1), .RATE(RATE_BUF), .INIT_VAL(1'b0), .RST_VAL(1'b0)) dut_buf (
        .clk_ser(clk_ser), .clk_par(clk_div), .rst(rst), .oe_ce(ce),
        .oe_par(t1), .oe_ser(ser_b), .oe_fb(fb_b));

    // Stimulus words; the expected serial order is bit 0 upward of each word.
    localparam logic [3:0] DVEC [8] = '{4'h5, 4'hA, 4'h3, 4'hC, 4'hF, 4'h0, 4'h9, 4'h6};
    localparam logic [3:0] SVEC [6] = '{4'h1, 4'h8, 4'hE, 4'h7, 4'h2, 4'hB};

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        rst = 1'b1; ce = 1'b1; par = DVEC[0]; t1 = 1'b0;
        repeat (3) @(posedge clk_div4);
        #5;
        chk("R1 ddr high phase", ser_d, 1'b1);
        chk("R8 ddr copy", fb_d, ser_d);
        chk("R1 sdr", ser_s, 1'b0);
        #10;
        chk("R1 ddr low phase", ser_d, 1'b1);
        t1 = 1'b1; #1;
        chk("R7 buf under reset", ser_b, 1'b1);
        chk("R8 buf copy", fb_b, 1'b1);
        t1 = 1'b0; #1;
        chk("R7 buf under reset", ser_b, 1'b0);

        @(posedge clk_div4); #65 rst = 1'b0;

        // Double-rate table walk.
        for (int i = 0; i < 8; i++) begin
            logic [3:0] e;
            string tg;
            e  = (i == 0) ? 4'b0000 : DVEC[i-1];
            tg = (i == 0) ? "R2 ddr init" : "R4 ddr slot";
            @(posedge clk_div);
            #5;  chk(tg, ser_d, e[0]); chk("R8 ddr copy", fb_d, ser_d);
            par = (i < 7) ? DVEC[i+1] : DVEC[7];
            #10; chk(tg, ser_d, e[1]); chk("R8 ddr copy", fb_d, ser_d);
            #10; chk(tg, ser_d, e[2]);
            #10; chk("R3 ddr order", ser_d, e[3]);
        end

        // Reset mid-run.
        rst = 1'b1;
        @(posedge clk_div4);
        #5;  chk("R1 ddr again", ser_d, 1'b1); chk("R1 sdr again", ser_s, 1'b0);
        #10; chk("R1 ddr again low", ser_d, 1'b1);
        par = SVEC[0];
        @(posedge clk_div4); #65 rst = 1'b0;

        // Single-rate table walk.
        for (int i = 0; i < 6; i++) begin
            logic [3:0] e;
            string tg;
            e  = (i == 0) ? 4'b1111 : SVEC[i-1];
            tg = (i == 0) ? "R2 sdr init" : "R5 sdr slot";
            @(posedge clk_div4);
            #5;  chk(tg, ser_s, e[0]); chk("R8 sdr copy", fb_s, ser_s);
            if (i == 0) chk("R2 ddr init after reset", ser_d, 1'b0);
            par = (i < 5) ? SVEC[i+1] : SVEC[5];
            #20; chk(tg, ser_s, e[1]);
            #20; chk(tg, ser_s, e[2]);
            #20; chk(tg, ser_s, e[3]);
        end

        // Clock-enable hold: shown 0,1 then held at 1 while 1001 arrives.
        par = 4'b0110;
        repeat (4) @(posedge clk_div);
        #5;  chk("R3 pre-hold", ser_d, 1'b0);
        ce = 1'b0; par = 4'b1001;
        #10; chk("R3 pre-hold", ser_d, 1'b1);
        for (int k = 0; k < 6; k++) begin
            #10; chk("R6 hold", ser_d, 1'b1);
        end
        @(posedge clk_div);
        #5;  chk("R6 hold", ser_d, 1'b1);
        ce = 1'b1;
        #10; chk("R6 hold to slot end", ser_d, 1'b1);
        #10; chk("R6 resume mid-word", ser_d, 1'b0);
        #10; chk("R6 resume mid-word", ser_d, 1'b1);
        @(posedge clk_div);
        #5;  chk("R6 full word after resume", ser_d, 1'b1);
        #10; chk("R6 full word after resume", ser_d, 1'b0);

        // Buffer mode ignores the enable.
        ce = 1'b0;
        t1 = 1'b1; #1; chk("R7 buf with ce low", ser_b, 1'b1);
        t1 = 1'b0; #1; chk("R7 buf with ce low", ser_b, 1'b0);
        ce = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule